// File: doc/BRIEF.md
# Real-Time Counter Interrupt Flag Unit

This block keeps the pending-interrupt flags of a 32-bit real-time counter. Three sources feed it: a one-cycle overflow pulse and a one-cycle compare-match pulse from the counter, and the free-running prescaler value. Each overflow or compare pulse sets its own flag on the clock edge that samples it. Eight periodic flags are set when one of the prescaler bits 9 down to 2 rises, with flag n following bit n+2.

Software reads the flags through a plain register port and clears them by writing ones. A write of zero leaves a flag alone. When a clear and a new event reach the same flag in one cycle, the event wins, so no event is lost. The flags are masked with an enable vector and ORed into one registered interrupt request.

Top module: `rtc_irq_flags`

## Requirements
- R1: After synchronous reset all flags are 0, `irq` is 0 and `rdata` is 0.
- R2: Reading address 0x0C gives the flags in this layout: bit 15 is overflow, bit 8 is compare 0, and bits 7:0 are periodic flags 7..0. Every other bit reads 0. Any other address reads 0. `rdata` is registered and shows the flag state one cycle after `addr` is presented. Reads change nothing.
- R3: An `ovf_evt` pulse sampled on a clock edge sets the overflow flag (bit 15) at that edge.
- R4: A `cmp_evt` pulse sampled on a clock edge sets the compare flag (bit 8) at that edge.
- R5: Periodic flag n (n = 0..7) is set at the edge where `presc[n+2]` is sampled as 1 after it was sampled as 0 on the previous edge. Edges on `presc[1:0]`, and falling edges, set nothing.
- R6: A write to 0x0C clears every implemented flag whose `wdata` bit is 1. Flags whose `wdata` bit is 0 keep their value. A write to any other address changes no flag.
- R7: If a set event and a clearing write hit the same flag in one cycle, the flag ends up set.
- R8: `irq` is registered. It is 1 in the cycle after `flags & irq_en` is nonzero and 0 in the cycle after it is zero, so it stays high until every enabled pending flag is cleared.
- R9: Writing ones to unimplemented bits has no effect. Those bits keep reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous active-high reset |
| ovf_evt | input | 1 | Counter overflow pulse |
| cmp_evt | input | 1 | Compare-0 match pulse |
| presc | input | PRESC_W | Running prescaler value |
| irq_en | input | 16 | Interrupt enable mask, same bit layout as the flags |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data, a 1 clears the flag |
| rdata | output | 16 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
A flag that is stuck, missed or wrongly cleared shows up in `rdata` two edges after the stimulus. It also shows up in `irq` on the same edge when that bit is enabled. The prescaler sweep runs through all 1024 values of bits 9:0, so a wrong bit offset or a falling-edge detector sets an unexpected periodic bit within one step. Set-versus-clear collisions and partial clear masks are checked by reading the register back right after the write.

// File: rtl/rtcf_pkg.sv
package rtcf_pkg;
  localparam int FLAG_W   = 16;
  localparam int OVF_BIT  = 15;
  localparam int CMP_BIT  = 8;
  localparam int PER_MAX  = 8;
  localparam int PER_BASE = 2;

  function automatic logic [FLAG_W-1:0] impl_mask(input int n_per);
    logic [FLAG_W-1:0] m;
    m = '0;
    m[OVF_BIT] = 1'b1;
    m[CMP_BIT] = 1'b1;
    for (int i = 0; i < n_per; i++) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/rtcf_per_edge.sv
module rtcf_per_edge #(
  parameter int N_PER = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_PER-1:0] taps,
  output logic [N_PER-1:0] rise
);
  logic [N_PER-1:0] taps_q;

  always_ff @(posedge clk) begin
    if (rst) taps_q <= '0;
    else     taps_q <= taps;
  end

  genvar g;
  generate
    for (g = 0; g < N_PER; g++) begin : g_det
      assign rise[g] = taps[g] & ~taps_q[g];
    end
  endgenerate

  // R5: a detected rise follows a sample of 0 on the previous edge
  a_r5_rise_after_low: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |-> ((taps & ~$past(taps)) == rise));
endmodule

// File: rtl/rtcf_flag_bits.sv
module rtcf_flag_bits #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)           q[g] <= 1'b0;
        else if (set_i[g]) q[g] <= 1'b1;
        else if (clr_i[g]) q[g] <= 1'b0;
      end

      // R7: a set always lands, even against a clear
      a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_i[g] |=> q[g]);
      // R6: a clear without a set empties the flag
      a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_i[g] && !set_i[g]) |=> !q[g]);
    end
  endgenerate
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
  parameter int              ADDR_W   = 6,
  parameter int              PRESC_W  = 10,
  parameter int              N_PER    = 8,
  parameter logic [ADDR_W-1:0] FLAG_OFF = 6'h0C
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ovf_evt,
  input  logic                        cmp_evt,
  input  logic [PRESC_W-1:0]          presc,
  input  logic [rtcf_pkg::FLAG_W-1:0] irq_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        wr_en,
  input  logic [rtcf_pkg::FLAG_W-1:0] wdata,
  output logic [rtcf_pkg::FLAG_W-1:0] rdata,
  output logic                        irq
);
  import rtcf_pkg::*;

  localparam logic [FLAG_W-1:0] MASK = impl_mask(N_PER);

  logic [N_PER-1:0]  per_rise;
  logic [FLAG_W-1:0] set_v, clr_v, flags;
  logic              wr_hit;
  logic [PER_BASE-1:0] unused_presc_lo;

  assign unused_presc_lo = presc[PER_BASE-1:0];

  rtcf_per_edge #(.N_PER(N_PER)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .taps (presc[PER_BASE +: N_PER]),
    .rise (per_rise)
  );

  always_comb begin
    set_v = '0;
    set_v[N_PER-1:0] = per_rise;
    set_v[OVF_BIT]   = ovf_evt;
    set_v[CMP_BIT]   = cmp_evt;
  end

  assign wr_hit = wr_en && (addr == FLAG_OFF);
  assign clr_v  = wr_hit ? (wdata & MASK) : '0;

  rtcf_flag_bits #(.W(FLAG_W)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set_i (set_v),
    .clr_i (clr_v),
    .q     (flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      rdata <= (addr == FLAG_OFF) ? (flags & MASK) : '0;
      irq   <= |(flags & irq_en);
    end
  end

  // R3: overflow pulse sets bit 15 at the sampling edge
  a_r3_ovf_set: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> flags[OVF_BIT]);
  // R4: compare pulse sets bit 8 at the sampling edge
  a_r4_cmp_set: assert property (@(posedge clk) disable iff (rst)
    cmp_evt |=> flags[CMP_BIT]);
  // R8: nothing enabled and pending means no request next cycle
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    ((flags & irq_en) == '0) |=> !irq);
  // R9: unimplemented bits never read as 1
  a_r9_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
    (rdata & ~MASK) == '0);
endmodule

// File: tb/sim_rtc_irq_flags.sv
`timescale 1ns/1ps
module sim_rtc_irq_flags;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ovf_evt = 1'b0, cmp_evt = 1'b0, wr_en = 1'b0;
  logic [9:0]  presc = '0;
  logic [15:0] irq_en = '0, wdata = '0;
  logic [5:0]  addr = 6'h0C;
  logic [15:0] rdata;
  logic        irq;
  int checks = 0, errors = 0;
  logic [15:0] exp_f = '0;
  logic [9:0]  prev_p = '0;

  always #4 clk = ~clk;

  rtc_irq_flags u0 (.clk(clk), .rst(rst), .ovf_evt(ovf_evt), .cmp_evt(cmp_evt),
    .presc(presc), .irq_en(irq_en), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq(irq));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one-cycle stimulus, then wait until rdata shows its effect
  task automatic act(input logic o, input logic c, input logic w, input logic [15:0] d);
    @(negedge clk); ovf_evt = o; cmp_evt = c; wr_en = w; wdata = d;
    @(negedge clk); ovf_evt = 0; cmp_evt = 0; wr_en = 0; wdata = '0;
    @(negedge clk);
  endtask

  task automatic step_p(input logic [9:0] v);
    @(negedge clk); presc = v;
    exp_f[7:0] = exp_f[7:0] | 8'((v & ~prev_p) >> 2);
    prev_p = v;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata", rdata, 16'h0); chk("R1 irq", {15'b0, irq}, 16'h0);
    rst = 0;
    @(negedge clk); @(negedge clk);
    chk("R1 flags", rdata, 16'h0);

    act(1, 0, 0, '0); exp_f[15] = 1; chk("R3 ovf", rdata, exp_f);
    act(0, 1, 0, '0); exp_f[8] = 1;  chk("R4 cmp", rdata, exp_f);
    act(0, 0, 1, 16'h0000); chk("R6 write zero keeps", rdata, exp_f);
    act(0, 0, 1, 16'h7EFF); chk("R9 unimpl ignored", rdata, exp_f);
    act(0, 0, 1, 16'h0100); exp_f[8] = 0; chk("R6 clear cmp only", rdata, exp_f);
    act(1, 0, 1, 16'h8000); chk("R7 set wins held", rdata, exp_f);
    act(0, 1, 1, 16'h0100); exp_f[8] = 1; chk("R7 set wins fresh", rdata, exp_f);
    // write to another address
    @(negedge clk); addr = 6'h10; wr_en = 1; wdata = 16'hFFFF;
    @(negedge clk); wr_en = 0; wdata = '0;
    chk("R2 other addr reads 0", rdata, 16'h0);
    @(negedge clk); addr = 6'h0C;
    @(negedge clk);
    chk("R6 other addr no clear", rdata, exp_f);

    // R8 interrupt masking
    act(0, 0, 1, 16'hFFFF); exp_f = '0; chk("R6 clear all", rdata, exp_f);
    chk("R8 irq idle", {15'b0, irq}, 16'h0);
    act(1, 0, 0, '0); exp_f[15] = 1;
    chk("R8 masked no irq", {15'b0, irq}, 16'h0);
    @(negedge clk); irq_en = 16'h8000;
    @(negedge clk); chk("R8 irq raised", {15'b0, irq}, 16'h1);
    act(0, 1, 0, '0); exp_f[8] = 1;
    act(0, 0, 1, 16'h0100); exp_f[8] = 0;
    chk("R8 irq held by ovf", {15'b0, irq}, 16'h1);
    act(0, 0, 1, 16'h8000); exp_f[15] = 0;
    chk("R8 irq dropped", {15'b0, irq}, 16'h0);
    irq_en = '0;

    // R5 exhaustive prescaler sweep, clearing every 64 steps
    for (int v = 0; v < 1024; v++) begin
      step_p(10'(v));
      chk("R5 periodic sweep", rdata, exp_f);
      if ((v % 64) == 63) begin
        act(0, 0, 1, 16'h00FF); exp_f[7:0] = '0;
        chk("R6 clear periodic", rdata, exp_f);
      end
    end
    step_p(10'h000); chk("R5 falling sets none", rdata, exp_f);
    step_p(10'h003); chk("R5 low bits ignored", rdata, exp_f);
    step_p(10'h200); chk("R5 bit9 to flag7", rdata, 16'h0080);
    @(negedge clk); irq_en = 16'h0080;
    @(negedge clk); chk("R8 periodic irq", {15'b0, irq}, 16'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule